// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Channel

This block is one memory-to-memory copy channel that works through a chain of descriptors held in memory. Software loads a start source address and a pointer to the first descriptor, then sets the channel enable. The channel also needs the global controller enable. It reads one descriptor and copies the block that descriptor describes, one word at a time. It then writes the descriptor's control word back with a completion mark and moves to the next descriptor. A zero next pointer ends the chain.

Only the destination address, the next pointer and the control word are taken from each descriptor. The source-address word is read and then discarded. The source address is therefore one running pointer: software seeds it once, and it advances across every block in the chain. The channel reports a single-cycle event after each block and another after the whole chain. When the chain ends it clears its own enable, so software may poll that enable instead of waiting for the events. A memory error response aborts the channel and raises an error event.

Top module: `llchain_dma`

## Requirements
- R1: The channel starts only while the channel enable (register select 2, bit 0) and the global enable (register select 3, bit 0) are both 1. With either one at 0 and the channel idle, `mem_req` stays low.
- R2: On start, the channel reads the four descriptor words at pointer+0, +4, +8 and +12, in that order. The pointer comes from register select 1.
- R3: The first source read uses the address written to register select 0. Each later source read is 4 higher than the one before, including across block boundaries, and the address is never reloaded from a descriptor.
- R4: The word at descriptor offset +4 is the destination address of that descriptor's first write. The destination address rises by 4 after each write in the block.
- R5: The word at descriptor offset +0 is read and then ignored; it changes no later address.
- R6: The block length in words is bits [11:0] of the control word at offset +12. Each word is read from the source and the same data is then written to the destination. A length of 0 causes no data access.
- R7: The cycle after the accept of a block's write-back, `blk_done` pulses for one cycle. For the last block, `xfer_done` pulses in that same cycle and `chan_en` reads 0.
- R8: After a block's last data write, the channel writes its control word to pointer+12 with bit 31 set and all other bits unchanged.
- R9: A non-zero next pointer (offset +8) makes the channel fetch the next descriptor at that address. A zero next pointer ends the transfer with no further access.
- R10: If `mem_err` is 1 on an accepted access, `err_evt` pulses in the next cycle. In that cycle `chan_en` is 0 and no block event fires, and no further access follows.
- R11: A request stays asserted, with address, direction and write data stable, until `mem_ack` accepts it. Only one access is in flight at a time.
- R12: While the channel is busy, writes to register selects 0, 1 and 2 are ignored. The running transfer keeps its addresses and its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 source, 1 descriptor pointer, 2 channel enable, 3 global enable |
| reg_wr_data | input | AW | Register write data |
| chan_en | output | 1 | Channel enable state, cleared by hardware at the end of a chain or on an error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | AW | Write data |
| mem_ack | input | 1 | Memory accepts and completes the current access |
| mem_err | input | 1 | Error response, valid together with mem_ack |
| mem_rdata | input | AW | Read data, valid together with mem_ack |
| blk_done | output | 1 | One-cycle pulse per completed block |
| xfer_done | output | 1 | One-cycle pulse when the chain is complete |
| err_evt | output | 1 | One-cycle pulse on an aborting error |

## Verification
Each check compares the channel's accesses and events with a reference model in the bench.

- **Three-descriptor chain.** The blocks are 2, 3 and 1 words long, with junk in the descriptors' source words and in the control word's upper bits. This run shows whether the source pointer runs on or is reloaded, and whether the discarded word leaks into any address.
- **Writes while busy.** During that chain the bench writes the source, pointer and enable registers. This separates ignored writes from writes that take effect mid-transfer.
- **Zero-length descriptor.** This run separates a block with no data access from one that wrongly copies a word.
- **Error on a mid-block source read.** This run separates a clean abort from one that goes on to write data or write back the descriptor.

Memory latency varies from access to access, which exposes any request that is dropped or changes before it is accepted.

// File: rtl/llchain_pkg.sv
package llchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DESC   = 3'd1,
    ST_SRC_RD = 3'd2,
    ST_DST_WR = 3'd3,
    ST_WBACK  = 3'd4
  } ch_state_e;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_CHEN = 2'd2,
    SEL_GCFG = 2'd3
  } reg_sel_e;

  // descriptor word order; the channel decodes words by this index
  localparam logic [1:0] DW_DST  = 2'd1;
  localparam logic [1:0] DW_NEXT = 2'd2;
  localparam logic [1:0] DW_CTRL = 2'd3;

endpackage

// File: rtl/llchain_regs.sv
module llchain_regs
  import llchain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          busy,
  input  logic          src_step,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_next,
  input  logic          en_clear,
  output logic          start,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] ptr_addr,
  output logic          chan_en,
  output logic          glob_en
);
  localparam logic [AW-1:0] STEP = AW'(AW / 8);

  logic [AW-1:0] src_q, src_d, ptr_q, ptr_d;
  logic          chen_q, chen_d, gen_q, gen_d;
  logic          idle_wr;

  assign idle_wr = wr_en && !busy;

  always_comb begin
    src_d  = src_q;
    ptr_d  = ptr_q;
    chen_d = chen_q;
    gen_d  = gen_q;
    if (idle_wr && (wr_sel == SEL_SRC)) begin
      src_d = wr_data;
    end else if (src_step) begin
      src_d = src_q + STEP;
    end
    if (idle_wr && (wr_sel == SEL_PTR)) begin
      ptr_d = wr_data;
    end else if (ptr_load) begin
      ptr_d = ptr_next;
    end
    if (en_clear) begin
      chen_d = 1'b0;
    end else if (idle_wr && (wr_sel == SEL_CHEN)) begin
      chen_d = wr_data[0];
    end
    if (wr_en && (wr_sel == SEL_GCFG)) begin
      gen_d = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      ptr_q  <= '0;
      chen_q <= 1'b0;
      gen_q  <= 1'b0;
    end else begin
      src_q  <= src_d;
      ptr_q  <= ptr_d;
      chen_q <= chen_d;
      gen_q  <= gen_d;
    end
  end

  assign start    = chen_q && gen_q && !busy;
  assign src_addr = src_q;
  assign ptr_addr = ptr_q;
  assign chan_en  = chen_q;
  assign glob_en  = gen_q;

endmodule

// File: rtl/llchain_ctrl.sv
module llchain_ctrl
  import llchain_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [AW-1:0] mem_rdata,
  output ch_state_e     state,
  output logic [1:0]    beat,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] nxt_ptr,
  output logic [AW-1:0] ctl_word,
  output logic [AW-1:0] data_word,
  output logic          busy,
  output logic          src_step,
  output logic          ptr_load,
  output logic          en_clear,
  output logic          blk_done,
  output logic          xfer_done,
  output logic          err_evt
);
  localparam logic [AW-1:0]    STEP    = AW'(AW / 8);
  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);
  localparam logic [LEN_W-1:0] NO_LEN  = '0;

  ch_state_e        st_q, st_d;
  logic [1:0]       beat_q, beat_d;
  logic [AW-1:0]    dst_q, dst_d, nxt_q, nxt_d, ctl_q, ctl_d, dat_q, dat_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             blk_q, blk_d, xfr_q, xfr_d, err_q, err_d;

  assign cnt_inc = cnt_q + ONE_LEN;

  always_comb begin
    st_d     = st_q;
    beat_d   = beat_q;
    dst_d    = dst_q;
    nxt_d    = nxt_q;
    ctl_d    = ctl_q;
    dat_d    = dat_q;
    cnt_d    = cnt_q;
    blk_d    = 1'b0;
    xfr_d    = 1'b0;
    err_d    = 1'b0;
    src_step = 1'b0;
    ptr_load = 1'b0;
    en_clear = 1'b0;
    if ((st_q != ST_IDLE) && mem_ack && mem_err) begin
      err_d    = 1'b1;
      en_clear = 1'b1;
      st_d     = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_d   = ST_DESC;
            beat_d = 2'd0;
          end
        end
        ST_DESC: begin
          if (mem_ack) begin
            beat_d = beat_q + 2'd1;
            if (beat_q == DW_DST) begin
              dst_d = mem_rdata;
            end
            if (beat_q == DW_NEXT) begin
              nxt_d = mem_rdata;
            end
            if (beat_q == DW_CTRL) begin
              ctl_d = mem_rdata;
              cnt_d = '0;
              st_d  = (mem_rdata[LEN_W-1:0] == NO_LEN) ? ST_WBACK : ST_SRC_RD;
            end
          end
        end
        ST_SRC_RD: begin
          if (mem_ack) begin
            dat_d    = mem_rdata;
            src_step = 1'b1;
            st_d     = ST_DST_WR;
          end
        end
        ST_DST_WR: begin
          if (mem_ack) begin
            dst_d = dst_q + STEP;
            cnt_d = cnt_inc;
            st_d  = (cnt_inc == ctl_q[LEN_W-1:0]) ? ST_WBACK : ST_SRC_RD;
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            blk_d = 1'b1;
            if (nxt_q == '0) begin
              xfr_d    = 1'b1;
              en_clear = 1'b1;
              st_d     = ST_IDLE;
            end else begin
              ptr_load = 1'b1;
              beat_d   = 2'd0;
              st_d     = ST_DESC;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      dst_q  <= '0;
      nxt_q  <= '0;
      ctl_q  <= '0;
      dat_q  <= '0;
      cnt_q  <= '0;
      blk_q  <= 1'b0;
      xfr_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      dst_q  <= dst_d;
      nxt_q  <= nxt_d;
      ctl_q  <= ctl_d;
      dat_q  <= dat_d;
      cnt_q  <= cnt_d;
      blk_q  <= blk_d;
      xfr_q  <= xfr_d;
      err_q  <= err_d;
    end
  end

  assign state     = st_q;
  assign beat      = beat_q;
  assign dst_addr  = dst_q;
  assign nxt_ptr   = nxt_q;
  assign ctl_word  = ctl_q;
  assign data_word = dat_q;
  assign busy      = (st_q != ST_IDLE);
  assign blk_done  = blk_q;
  assign xfer_done = xfr_q;
  assign err_evt   = err_q;

endmodule

// File: rtl/llchain_mreq.sv
module llchain_mreq
  import llchain_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DONE_BIT = 31
) (
  input  ch_state_e     state,
  input  logic [1:0]    beat,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] ptr_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] data_word,
  input  logic [AW-1:0] ctl_word,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata
);
  localparam logic [AW-1:0] STEP      = AW'(AW / 8);
  localparam logic [AW-1:0] DONE_MASK = {{(AW-1){1'b0}}, 1'b1} << DONE_BIT;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_addr;
    mem_wdata = '0;
    unique case (state)
      ST_DESC: begin
        mem_req  = 1'b1;
        mem_addr = ptr_addr + (AW'(beat) * STEP);
      end
      ST_SRC_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_addr;
      end
      ST_DST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_addr;
        mem_wdata = data_word;
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_addr + (AW'(DW_CTRL) * STEP);
        mem_wdata = ctl_word | DONE_MASK;
      end
      default: begin
        mem_req = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/llchain_dma.sv
module llchain_dma
  import llchain_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LEN_W    = 12,
  parameter int DONE_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_wr_sel,
  input  logic [AW-1:0] reg_wr_data,
  output logic          chan_en,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [AW-1:0] mem_rdata,
  output logic          blk_done,
  output logic          xfer_done,
  output logic          err_evt
);
  ch_state_e     st_w;
  logic [1:0]    beat_w;
  logic [AW-1:0] src_addr_w, ptr_addr_w, dst_addr_w, nxt_ptr_w, ctl_word_w, data_word_w;
  logic          start_w, busy_w, src_step_w, ptr_load_w, en_clear_w, glob_en_w;
  logic          in_desc_w;

  llchain_regs #(.AW(AW)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_sel   (reg_wr_sel),
    .wr_data  (reg_wr_data),
    .busy     (busy_w),
    .src_step (src_step_w),
    .ptr_load (ptr_load_w),
    .ptr_next (nxt_ptr_w),
    .en_clear (en_clear_w),
    .start    (start_w),
    .src_addr (src_addr_w),
    .ptr_addr (ptr_addr_w),
    .chan_en  (chan_en),
    .glob_en  (glob_en_w)
  );

  llchain_ctrl #(.AW(AW), .LEN_W(LEN_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .state     (st_w),
    .beat      (beat_w),
    .dst_addr  (dst_addr_w),
    .nxt_ptr   (nxt_ptr_w),
    .ctl_word  (ctl_word_w),
    .data_word (data_word_w),
    .busy      (busy_w),
    .src_step  (src_step_w),
    .ptr_load  (ptr_load_w),
    .en_clear  (en_clear_w),
    .blk_done  (blk_done),
    .xfer_done (xfer_done),
    .err_evt   (err_evt)
  );

  llchain_mreq #(.AW(AW), .DONE_BIT(DONE_BIT)) mreq_i (
    .state     (st_w),
    .beat      (beat_w),
    .src_addr  (src_addr_w),
    .ptr_addr  (ptr_addr_w),
    .dst_addr  (dst_addr_w),
    .data_word (data_word_w),
    .ctl_word  (ctl_word_w),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign in_desc_w = (st_w == ST_DESC);

endmodule

// File: rtl/llchain_dma_chk.sv
module llchain_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          blk_done,
  input logic          xfer_done,
  input logic          err_evt,
  input logic          chan_en,
  input logic          busy,
  input logic          glob_en,
  input logic          in_desc,
  input logic [AW-1:0] src_addr
);

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(chan_en && glob_en)) |=> !mem_req);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_desc_keeps_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_desc && mem_ack) |=> $stable(src_addr));

  p_xfer_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (blk_done && !chan_en && !busy));

  p_err_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> (!chan_en && !busy && !blk_done && !xfer_done && !mem_req));

endmodule

bind llchain_dma llchain_dma_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .blk_done  (blk_done),
  .xfer_done (xfer_done),
  .err_evt   (err_evt),
  .chan_en   (chan_en),
  .busy      (busy_w),
  .glob_en   (glob_en_w),
  .in_desc   (in_desc_w),
  .src_addr  (src_addr_w)
);

// File: tb/llchain_dma_tb.sv
module llchain_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        chan_en, mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        blk_done, xfer_done, err_evt;

  always #4 clk = ~clk;

  llchain_dma dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .chan_en(chan_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .blk_done(blk_done), .xfer_done(xfer_done), .err_evt(err_evt)
  );

  typedef struct {
    logic [31:0] addr;
    bit          we;
    logic [31:0] wdata;
    bit          wb;
    bit          last;
    bit          err;
  } acc_t;

  acc_t        expq[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0, failures = 0;
  bit          mon_on = 0, stray = 0, done_seen = 0;
  bit          exp_blk = 0, exp_xfr = 0, exp_err = 0;
  int          wait_cnt = 0, seed = 7;
  int          n_blk = 0, n_xfr = 0, n_err = 0, req_cycles = 0, cyc = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFC;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input bit we, input logic [31:0] d,
                      input bit wb, input bit last);
    acc_t e;
    e.addr = a; e.we = we; e.wdata = d; e.wb = wb; e.last = last;
    e.err = (a == err_addr);
    expq.push_back(e);
  endtask

  // reference model: walk the chain in the bench's memory and list every access
  task automatic build_exp(input logic [31:0] src0, input logic [31:0] p0);
    logic [31:0] p, src, dst, nxt, ctl;
    int len;
    p = p0; src = src0;
    forever begin
      for (int k = 0; k < 4; k++) begin
        push(p + 32'(4 * k), 1'b0, 32'h0, 1'b0, 1'b0);
        if (p + 32'(4 * k) == err_addr) return;
      end
      dst = rd(p + 32'd4); nxt = rd(p + 32'd8); ctl = rd(p + 32'd12);
      len = int'(ctl[11:0]);
      for (int i = 0; i < len; i++) begin
        push(src, 1'b0, 32'h0, 1'b0, 1'b0);
        if (src == err_addr) return;
        push(dst, 1'b1, rd(src), 1'b0, 1'b0);
        if (dst == err_addr) return;
        src = src + 32'd4; dst = dst + 32'd4;
      end
      push(p + 32'd12, 1'b1, ctl | 32'h8000_0000, 1'b1, nxt == 32'h0);
      if (nxt == 32'h0 || p + 32'd12 == err_addr) return;
      p = nxt;
    end
  endtask

  // memory model and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      check(blk_done == exp_blk && xfer_done == exp_xfr && err_evt == exp_err,
            "R7 R10", "event outputs {blk,xfer,err}",
            {29'h0, blk_done, xfer_done, err_evt}, {29'h0, exp_blk, exp_xfr, exp_err});
      if (blk_done) n_blk++;
      if (xfer_done) n_xfr++;
      if (err_evt) n_err++;
      if (xfer_done || err_evt) done_seen = 1;
      exp_blk = 0; exp_xfr = 0; exp_err = 0;
      mem_ack = 1'b0; mem_err = 1'b0;
      if (mem_req) begin
        req_cycles++;
        if (expq.size() == 0) begin
          if (!stray) check(1'b0, "R9 R10", "unexpected request address", mem_addr, 32'h0);
          stray = 1;
        end else if (wait_cnt > 0) begin
          wait_cnt--;
        end else begin
          acc_t e;
          e = expq.pop_front();
          check(mem_addr == e.addr && mem_we == e.we, "R2 R3 R4 R5 R6 R8 R9 R12",
                mem_we ? "write address" : "read address", mem_addr, e.addr);
          if (e.we) check(mem_wdata == e.wdata, "R6 R8", "write data", mem_wdata, e.wdata);
          mem_ack = 1'b1;
          mem_err = e.err;
          mem_rdata = rd(mem_addr);
          if (mem_we && !e.err) mem[mem_addr] = mem_wdata;
          exp_blk = e.wb && !e.err;
          exp_xfr = e.wb && e.last && !e.err;
          exp_err = e.err;
          seed = seed * 1103515245 + 12345;
          wait_cnt = (seed >>> 8) & 3;
          if (wait_cnt == 3) wait_cnt = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 5000 && !done_seen; i++) @(negedge clk);
    check(done_seen, req, "chain finished", {31'h0, done_seen}, 32'h1);
    repeat (12) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_blk = 0; n_xfr = 0; n_err = 0; done_seen = 0; req_cycles = 0;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = 2'd0; reg_wr_data = 32'h0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 32'h0;
    // chain of three descriptors, junk in the source words and upper control bits
    mem[32'h1000] = 32'hDEAD_BEEF; mem[32'h1004] = 32'h4000;
    mem[32'h1008] = 32'h1100;      mem[32'h100C] = 32'h0005_A002;
    mem[32'h1100] = 32'h0BAD_0000; mem[32'h1104] = 32'h5000;
    mem[32'h1108] = 32'h1200;      mem[32'h110C] = 32'h0000_3003;
    mem[32'h1200] = 32'h1234_5678; mem[32'h1204] = 32'h6000;
    mem[32'h1208] = 32'h0;         mem[32'h120C] = 32'h0000_0001;
    // zero-length descriptor
    mem[32'h1300] = 32'h0; mem[32'h1304] = 32'h7000;
    mem[32'h1308] = 32'h0; mem[32'h130C] = 32'h0000_0000;
    mem[32'h7000] = 32'h5EED_5EED;
    // descriptor whose block hits an error on its second source read
    mem[32'h1400] = 32'h0; mem[32'h1404] = 32'h7100;
    mem[32'h1408] = 32'h1500; mem[32'h140C] = 32'h0000_0004;
    for (int i = 0; i < 16; i++) begin
      mem[32'h2000 + 32'(4 * i)] = 32'hA500_0000 + 32'(i);
      mem[32'h2200 + 32'(4 * i)] = 32'hC300_0000 + 32'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !chan_en && !blk_done && !xfer_done && !err_evt, "R1 R7",
          "reset state {req,chen,blk,xfer,err}",
          {27'h0, mem_req, chan_en, blk_done, xfer_done, err_evt}, 32'h0);
    mon_on = 1;

    // R1: channel enable alone does not start
    clear_counts();
    reg_wr(SEL_SRC_V, 32'h2000);
    reg_wr(SEL_PTR_V, 32'h1000);
    reg_wr(SEL_CHEN_V, 32'h1);
    repeat (20) @(negedge clk);
    check(req_cycles == 0, "R1", "requests without global enable", 32'(req_cycles), 32'h0);
    check(chan_en == 1'b1, "R1", "channel enable held", {31'h0, chan_en}, 32'h1);

    // R2..R9, R12: three-block chain, writes while busy
    build_exp(32'h2000, 32'h1000);
    reg_wr(SEL_GCFG_V, 32'h1);
    repeat (15) @(negedge clk);
    reg_wr(SEL_SRC_V, 32'h9990);
    reg_wr(SEL_PTR_V, 32'h1300);
    reg_wr(SEL_CHEN_V, 32'h0);
    wait_done("R9");
    check(n_blk == 3, "R7", "block events", 32'(n_blk), 32'd3);
    check(n_xfr == 1, "R7", "transfer events", 32'(n_xfr), 32'd1);
    check(chan_en == 1'b0, "R7", "enable cleared at end", {31'h0, chan_en}, 32'h0);
    check(expq.size() == 0, "R9", "accesses left", 32'(expq.size()), 32'h0);
    check(rd(32'h5008) == 32'hA500_0004, "R3", "source ran on into block 2", rd(32'h5008), 32'hA500_0004);
    check(rd(32'h6000) == 32'hA500_0005, "R3 R4", "block 3 first word", rd(32'h6000), 32'hA500_0005);
    check(rd(32'h100C) == 32'h8005_A002, "R8", "written-back control", rd(32'h100C), 32'h8005_A002);

    // R6: zero-length block
    clear_counts();
    reg_wr(SEL_SRC_V, 32'h2100);
    reg_wr(SEL_PTR_V, 32'h1300);
    build_exp(32'h2100, 32'h1300);
    reg_wr(SEL_CHEN_V, 32'h1);
    wait_done("R6");
    check(rd(32'h7000) == 32'h5EED_5EED, "R6", "no data write", rd(32'h7000), 32'h5EED_5EED);
    check(n_blk == 1 && n_xfr == 1, "R6 R7", "events for empty block", 32'(n_blk + n_xfr), 32'd2);
    check(rd(32'h130C) == 32'h8000_0000, "R8", "empty block write-back", rd(32'h130C), 32'h8000_0000);

    // R10: error on second source read
    clear_counts();
    err_addr = 32'h2204;
    reg_wr(SEL_SRC_V, 32'h2200);
    reg_wr(SEL_PTR_V, 32'h1400);
    build_exp(32'h2200, 32'h1400);
    reg_wr(SEL_CHEN_V, 32'h1);
    wait_done("R10");
    check(n_err == 1 && n_blk == 0 && n_xfr == 0, "R10", "error-only events",
          32'(n_err * 100 + n_blk * 10 + n_xfr), 32'd100);
    check(chan_en == 1'b0, "R10", "enable cleared on error", {31'h0, chan_en}, 32'h0);
    check(rd(32'h7104) == 32'h0 && rd(32'h140C) == 32'h4, "R10", "no write after abort",
          rd(32'h7104) | rd(32'h140C), 32'h4);
    check(!stray && expq.size() == 0, "R10", "stray or missing access", 32'(expq.size()), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [1:0] SEL_SRC_V  = 2'd0;
  localparam logic [1:0] SEL_PTR_V  = 2'd1;
  localparam logic [1:0] SEL_CHEN_V = 2'd2;
  localparam logic [1:0] SEL_GCFG_V = 2'd3;

endmodule